// File: doc/BRIEF.md
# Glitch-free selectable card clock divider

This block produces the clock sent to a smart card contact from a free-running source clock, dividing it by 1, 2, 4 or 8 as picked by a two-bit select. The host may change the ratio while the card clock is toggling. The new ratio is only adopted at a boundary between output phases, so that no runt pulse appears and the pulses on both sides of the switch keep full width. A run input from the activation sequencer starts the card clock or parks it low. When it parks, the current high phase always completes first.

All output edges are flop edges. The divider is clocked by a reference `clk` running at twice the source clock rate, so one source period is two reference cycles. A ratio of N therefore gives high and low phases of N reference cycles each, and a full output period of 2N reference cycles, which equals N source periods. The select and run inputs are asynchronous to `clk`, and each passes through a two-stage synchronizer before the divider uses it.

Top module: `cardclk_div`

## Requirements
- R1: Select encoding, with `div_sel[1]` as the first bit and `div_sel[0]` as the second: 00 divides by 8, 01 by 4, 11 by 2, and 10 passes the source rate through (divide by 1). With run held high and the select steady, every high phase and every low phase lasts exactly N `clk` cycles.
- R2: While `rst_n` is low, `card_clk` is low and the divider is idle with ratio code 00. After release, `card_clk` stays low until run is seen high.
- R3: `div_sel` and `run_en` each reach the divider through two flops. A level applied before `clk` edge k is acted on at edge k+2.
- R4: A new ratio is adopted only at a phase boundary, meaning the edge where the current phase count runs out. This is no more than 2 + N_old `clk` cycles after the select changes, which is within 8 source periods.
- R5: Every completed high phase lasts 1, 2, 4 or 8 cycles and equals the ratio in force at its rising edge. No phase around a ratio change is shorter than the smaller of the two half-periods involved.
- R6: When run is seen low, the high phase in progress completes at full width and is followed by a full low phase. `card_clk` then stays low for as long as run stays low.
- R7: When run is seen high while the output is parked, the first high phase lasts the full half-period of the ratio in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the source clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio select (encoding in R1); change one bit at a time |
| run_en | input | 1 | Sequencer gate: 1 lets the card clock run, 0 parks it low |
| card_clk | output | 1 | Divided card clock |

## Verification
The bench first holds each ratio steady, which separates the four codes by their exact phase width. It then steps the select through every ordered pair of ratios, landing the change at a different offset into the output phase each time. This tells apart adoption at a boundary from adoption in the middle of a phase, and catches the sync latency being off by one. Run is dropped in the middle of a high phase and raised again from the parked state, which separates a clean park and restart from a clipped pulse. A cycle-exact behavioural model is compared on every cycle, alongside a width monitor on every high phase.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  localparam int unsigned MAX_RATIO = 8;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);
  localparam int unsigned RATIO_W   = CNT_W + 1;

  typedef enum logic [1:0] {
    SEL_DIV8 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_DIV2 = 2'b11,
    SEL_DIV1 = 2'b10
  } ratio_sel_e;

  // Half-period length in reference cycles for a select code.
  function automatic logic [RATIO_W-1:0] half_len(input logic [1:0] code);
    case (ratio_sel_e'(code))
      SEL_DIV8: half_len = RATIO_W'(8);
      SEL_DIV4: half_len = RATIO_W'(4);
      SEL_DIV2: half_len = RATIO_W'(2);
      default:  half_len = RATIO_W'(1);
    endcase
  endfunction

  // Counter preload: the phase ends when the counter reaches zero.
  function automatic logic [CNT_W-1:0] half_load(input logic [1:0] code);
    logic [RATIO_W-1:0] n;
    n = half_len(code) - RATIO_W'(1);
    half_load = n[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/cardclk_sync.sv
module cardclk_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase
  import cardclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_s,
  input  logic       run_s,
  output logic       clk_o,
  output logic       phase_end,
  output logic [1:0] ratio_q
);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  assign phase_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= SEL_DIV8;
    end else if (!phase_end) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else begin
      // Safe boundary: the ratio may change here only.
      ratio_q <= sel_s;
      if (lvl_q) begin
        lvl_q <= 1'b0;
        cnt_q <= half_load(sel_s);
      end else if (run_s) begin
        lvl_q <= 1'b1;
        cnt_q <= half_load(sel_s);
      end
    end
  end

  assign clk_o = lvl_q;

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       run_en,
  output logic       card_clk
);

  logic [2:0] ctl_raw;
  logic [2:0] ctl_sync;
  logic [1:0] sel_sync;
  logic       run_sync;
  logic       phase_end;
  logic [1:0] ratio_q;

  assign ctl_raw  = {run_en, div_sel};
  assign sel_sync = ctl_sync[1:0];
  assign run_sync = ctl_sync[2];

  cardclk_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ctl_raw),
    .sync_out (ctl_sync)
  );

  cardclk_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_sync),
    .run_s     (run_sync),
    .clk_o     (card_clk),
    .phase_end (phase_end),
    .ratio_q   (ratio_q)
  );

endmodule

// File: rtl/cardclk_div_chk.sv
module cardclk_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       card_clk,
  input logic       phase_end,
  input logic       run_sync,
  input logic [1:0] ratio_q
);

  logic       prev_lvl;
  logic [4:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= 1'b0;
      run_len  <= 5'd1;
    end else begin
      prev_lvl <= card_clk;
      if (card_clk != prev_lvl) run_len <= 5'd1;
      else if (run_len != 5'd31) run_len <= run_len + 5'd1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R2: assert (card_clk == 1'b0);
    end
  end

  assert_edge_only_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> $stable(card_clk));

  assert_ratio_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> $stable(ratio_q));

  assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_lvl && !card_clk) |-> ($onehot(run_len) && run_len <= 5'd8));

  assert_park_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_sync && !card_clk) |=> !card_clk);

  assert_high_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && card_clk) |=> !card_clk);

endmodule

bind cardclk_div cardclk_div_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_clk  (card_clk),
  .phase_end (phase_end),
  .run_sync  (run_sync),
  .ratio_q   (ratio_q)
);

// File: tb/tb_cardclk_div.sv
module tb_cardclk_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       run = 1'b0;
  logic       card_clk;

  always #5 clk = ~clk;

  cardclk_div dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_sel  (sel),
    .run_en   (run),
    .card_clk (card_clk)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R2";
  bit    done = 1'b0;

  // Behavioural model state
  int         m_out, m_rem;
  logic [1:0] h1s, h2s, s_now;
  logic       h1g, h2g, g_now;
  int         cur_len, last_high, prev_lvl;

  function automatic int ratio_of(logic [1:0] c);
    int e;
    e = c[1] ? int'(c[0]) : 3 - int'(c[0]);
    return 1 << e;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_rem = 0;
      h1s = 2'b00; h2s = 2'b00; h1g = 1'b0; h2g = 1'b0;
      cur_len = 0; prev_lvl = 0; last_high = 0;
      check(card_clk === 1'b0, "R2", "card_clk in reset", int'(card_clk), 0);
    end else begin
      check(card_clk === m_out[0], tag, "card_clk vs model", int'(card_clk), m_out);
      if (int'(card_clk) != prev_lvl) begin
        if (prev_lvl == 1) begin
          last_high = cur_len;
          check(cur_len inside {1, 2, 4, 8}, "R5", "high width", cur_len, 8);
        end
        cur_len = 1;
        prev_lvl = int'(card_clk);
      end else begin
        cur_len++;
      end
      // advance model to next edge (R3: two-edge sync delay)
      s_now = h2s; g_now = h2g;
      h2s = h1s; h2g = h1g;
      h1s = sel; h1g = run;
      if (m_rem > 0) m_rem--;
      else if (m_out == 1) begin m_out = 0; m_rem = ratio_of(s_now) - 1; end
      else if (g_now) begin m_out = 1; m_rem = ratio_of(s_now) - 1; end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drive(logic [1:0] s, logic g);
    @(posedge clk); #2;
    sel = s; run = g;
  endtask

  // one select bit at a time
  task automatic move_to(logic [1:0] t);
    if (sel[0] != t[0] && sel[1] != t[1]) begin
      drive({sel[1], t[0]}, run);
      wait_cyc(3);
    end
    drive(t, run);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    wait_cyc(4);
    #2 rst_n = 1'b1;
    wait_cyc(8);
    check(card_clk === 1'b0, "R2", "parked after reset", int'(card_clk), 0);

    // R1: each ratio held steady
    tag = "R1";
    for (int i = 0; i < 4; i++) begin
      logic [1:0] c;
      c = (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : (i == 2) ? 2'b11 : 2'b10;
      drive(c, 1'b1);
      wait_cyc(45);
      check(last_high == ratio_of(c), "R1", "steady high width", last_high, ratio_of(c));
    end

    // R4: every ordered pair of ratios, varied change offset
    tag = "R4";
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [1:0] ca, cb;
        if (a == b) continue;
        ca = 2'(a); cb = 2'(b);
        move_to(ca);
        wait_cyc(30 + ((a * 4 + b) % 7));
        move_to(cb);
        wait_cyc(34);
        check(last_high == ratio_of(cb), "R4", "width after change", last_high, ratio_of(cb));
      end
    end

    // R6: drop run during a /8 high phase
    tag = "R6";
    move_to(2'b00);
    wait_cyc(40);
    for (int k = 0; k < 40 && card_clk !== 1'b1; k++) @(negedge clk);
    drive(2'b00, 1'b0);
    wait_cyc(40);
    check(card_clk === 1'b0, "R6", "parked low", int'(card_clk), 0);
    check(last_high == 8, "R6", "last high kept full", last_high, 8);

    // R7: restart from parked state
    tag = "R7";
    drive(2'b00, 1'b1);
    wait_cyc(20);
    check(last_high == 8, "R7", "first high full", last_high, 8);
    drive(2'b00, 1'b0);
    wait_cyc(20);
    move_to(2'b01); wait_cyc(2); move_to(2'b11); wait_cyc(2); move_to(2'b10);
    wait_cyc(6);
    drive(2'b10, 1'b1);
    wait_cyc(8);
    check(last_high == 1, "R7", "first high at /1", last_high, 1);

    // R3: one-cycle run blip while parked low
    tag = "R3";
    drive(2'b11, 1'b0);
    wait_cyc(12);
    drive(2'b11, 1'b1);
    drive(2'b11, 1'b0);
    wait_cyc(12);
    check(card_clk === 1'b0, "R3", "parked after blip", int'(card_clk), 0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 20000, 0);
      report();
      $finish;
    end
  end

endmodule